// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block makes the bit clock for a synchronous serial port. It takes one of two sources: a free-running prescaled copy of the system clock, or an external clock pin. It divides the chosen source by a programmable 8-bit divisor. All logic runs in the system clock domain. The output is a registered level that toggles on system clock edges, and it is never used as a clock itself.

The divided clock goes out through a polarity control. Two one-cycle strobes, one for each rising and one for each falling edge of the uninverted clock, let the downstream shift logic act on bit boundaries without edge detectors of its own.

A divisor written while the divider runs takes effect only when the current output period ends, so a change never shortens a high or low phase. The enable input works as follows:
- Low: it parks the output at its inactive level.
- Rising: it starts a new period in the high phase.

Top module: `bclk_gen`

## Requirements
- R1: With `src_sel` = 1 the divider counts one input cycle every 4 system clock cycles. With `src_sel` = 0 it counts one input cycle per rising edge of `ext_clk`, after a two-flop synchronizer.
- R2: For a divisor N from 1 to 255, every output period lasts exactly N+1 input cycles.
- R3: For N from 1 to 255 the uninverted output is high for floor(N/2)+1 input cycles and low for the remainder of the period. Even N therefore has a high phase one input cycle longer than the low phase, and odd N has equal phases.
- R4: A divisor of 0 makes the uninverted output follow the selected source level, delayed by a fixed pipeline. In system-source mode this gives 2 system cycles high and 2 low.
- R5: `bclk` equals the uninverted output when `pol` = 0, and its complement when `pol` = 1.
- R6: `rise_stb` is high for exactly the one system cycle in which the uninverted output first reads 1 after reading 0. `fall_stb` does the same for each 1-to-0 change. The two strobes are never high together.
- R7: A new `divisor` value is adopted only at the end of a complete output period. The period in progress finishes with the old high and low lengths.
- R8: While `rst` is high, the uninverted output and both strobes are 0. After reset, with `en` low, `bclk` stays equal to `pol`.
- R9: With `en` low, `bclk` reaches and holds the level `pol` one cycle after the falling edge of `en`. In the cycle after `en` is first sampled high with a nonzero divisor, the uninverted output is 1, which opens a new period in the high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the output at its inactive level |
| src_sel | input | 1 | 1: system clock divided by 4; 0: external clock pin |
| ext_clk | input | 1 | External source clock, asynchronous to `clk` |
| divisor | input | 8 | Divide value N; period is N+1 input cycles, 0 passes the source through |
| pol | input | 1 | Output polarity; 1 inverts `bclk` |
| bclk | output | 1 | Divided bit clock after the polarity control |
| rise_stb | output | 1 | One-cycle pulse on each rise of the uninverted bit clock |
| fall_stb | output | 1 | One-cycle pulse on each fall of the uninverted bit clock |

## Verification
Each fault shows at the ports, and each shows within one or two output periods of the error:
- A phase counter that wraps at the wrong count stretches or shortens the next high or low phase. This shows at the first full period after a restart, because each phase length is measured in system cycles against the formula.
- A divisor latched too early shows as a wrong phase length in the period in which it was written. A divisor latched too late shows in the period after that.
- A strobe that drifts from the clock level is caught on the first edge where the two disagree.
- A lost synchronizer stage, or a wrong prescale count, changes every measured period.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

   // Source selector encoding as seen on the src_sel pin.
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_SYS = 1'b1
   } src_mode_e;

   // Input cycles spent high for a nonzero divide value n.
   function automatic int unsigned high_ticks(input int unsigned n);
      return (n / 2) + 1;
   endfunction

endpackage

// File: rtl/bclk_src.sv
module bclk_src
   import bclk_pkg::*;
#(
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  src_mode_e mode,
   input  logic      ext_clk,
   output logic      src_lvl,
   output logic      src_tick
);

   localparam int CNT_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam int HALF   = PRESCALE / 2;
   localparam int GAP_W  = $clog2(PRESCALE + 1) + 1;

   generate
      if (PRESCALE < 2 || (PRESCALE % 2) != 0) begin : g_bad_prescale
         $error("bclk_src: PRESCALE must be even and at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bclk_src: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Prescaler: square wave at the system clock divided by PRESCALE.
   logic [CNT_W-1:0] pre_cnt;
   logic [CNT_W-1:0] pre_nxt;
   logic             pre_lvl;

   always_comb begin
      if (pre_cnt == CNT_W'(PRESCALE - 1))
         pre_nxt = '0;
      else
         pre_nxt = pre_cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_cnt <= '0;
         pre_lvl <= 1'b0;
      end else begin
         pre_cnt <= pre_nxt;
         pre_lvl <= (pre_nxt >= CNT_W'(HALF));
      end
   end

   // Synchronizer chain for the external clock.
   logic [SYNC_STAGES-1:0] sync_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) sync_q[0] <= 1'b0;
               else     sync_q[0] <= ext_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) sync_q[s] <= 1'b0;
               else     sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   // Selected level and its rising-edge detector.
   logic sel_lvl;
   logic lvl_q;
   logic prev_q;

   assign sel_lvl = (mode == SRC_SYS) ? pre_lvl : sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         lvl_q  <= sel_lvl;
         prev_q <= lvl_q;
      end
   end

   assign src_lvl  = lvl_q;
   assign src_tick = lvl_q & ~prev_q;

   // Checker state: spacing between ticks once the mode has settled.
   logic [GAP_W-1:0] gap;
   logic [1:0]       seen;
   src_mode_e        mode_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap    <= '0;
         seen   <= 2'd0;
         mode_q <= SRC_EXT;
      end else begin
         mode_q <= mode;
         if (src_tick)
            gap <= '0;
         else if (gap != {GAP_W{1'b1}})
            gap <= gap + GAP_W'(1);
         if (mode != mode_q)
            seen <= 2'd0;
         else if (src_tick && seen != 2'd3)
            seen <= seen + 2'd1;
      end
   end

   assert_sys_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
      (mode == SRC_SYS && mode_q == SRC_SYS && src_tick && seen == 2'd3)
         |-> (gap == GAP_W'(PRESCALE - 1)));

   assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
      src_tick |=> !src_tick);

endmodule

// File: rtl/bclk_div_core.sv
module bclk_div_core
   import bclk_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DIV_W-1:0] divisor,
   input  logic             src_lvl,
   input  logic             src_tick,
   output logic             raw_lvl
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("bclk_div_core: DIV_W must be in 1..16");
      end
   endgenerate

   logic [DIV_W-1:0] pos;
   logic [DIV_W-1:0] pos_inc;
   logic [DIV_W-1:0] nact;
   logic             out_raw;
   logic             run;
   logic             lvl_d;
   logic             wrap;

   assign pos_inc = pos + DIV_W'(1);
   assign wrap    = (pos == nact);

   always_ff @(posedge clk) begin
      if (rst) begin
         pos     <= '0;
         nact    <= divisor;
         out_raw <= 1'b0;
         run     <= 1'b0;
         lvl_d   <= 1'b0;
      end else begin
         lvl_d <= src_lvl;
         run   <= en;
         if (!en) begin
            out_raw <= 1'b0;
         end else if (!run) begin
            pos     <= '0;
            nact    <= divisor;
            out_raw <= 1'b1;
         end else if (src_tick) begin
            if (wrap) begin
               pos     <= '0;
               nact    <= divisor;
               out_raw <= 1'b1;
            end else begin
               pos     <= pos_inc;
               out_raw <= (pos_inc <= (nact >> 1));
            end
         end
      end
   end

   // Divide-by-one bypass follows the delayed source level directly.
   always_comb begin
      if (!run)
         raw_lvl = 1'b0;
      else if (nact == '0)
         raw_lvl = lvl_d;
      else
         raw_lvl = out_raw;
   end

   // Checker: count input ticks spent in the high phase of each period.
   logic [DIV_W:0] hi_cnt;
   logic           hi_valid;
   logic           out_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_cnt   <= '0;
         hi_valid <= 1'b0;
         out_q    <= 1'b0;
      end else begin
         out_q <= out_raw;
         if (!en || !run) begin
            hi_cnt   <= '0;
            hi_valid <= 1'b0;
         end else if (src_tick && wrap) begin
            hi_cnt   <= '0;
            hi_valid <= 1'b1;
         end else if (src_tick && out_raw) begin
            hi_cnt <= hi_cnt + (DIV_W+1)'(1);
         end
      end
   end

   assert_pos_bound_R2: assert property (@(posedge clk) disable iff (rst)
      run |-> (pos <= nact));

   assert_high_len_R3: assert property (@(posedge clk) disable iff (rst)
      (run && hi_valid && out_q && !out_raw && nact != '0)
         |-> (hi_cnt == (DIV_W+1)'(high_ticks(int'(nact)))));

   assert_reload_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (run && $past(run) && !$stable(nact)) |-> (pos == '0));

   assert_disable_low_R9: assert property (@(posedge clk) disable iff (rst)
      !en |=> !raw_lvl);

   assert_start_high_R9: assert property (@(posedge clk) disable iff (rst)
      (en && !run && divisor != '0) |=> raw_lvl);

endmodule

// File: rtl/bclk_edge_out.sv
module bclk_edge_out (
   input  logic clk,
   input  logic rst,
   input  logic raw_lvl,
   input  logic pol,
   output logic bclk,
   output logic rise_stb,
   output logic fall_stb
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= raw_lvl;
   end

   assign bclk     = raw_lvl ^ pol;
   assign rise_stb = raw_lvl & ~prev_q;
   assign fall_stb = ~raw_lvl & prev_q;

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(rise_stb && fall_stb));

   assert_rise_once_R6: assert property (@(posedge clk) disable iff (rst)
      rise_stb |=> !rise_stb);

   assert_fall_once_R6: assert property (@(posedge clk) disable iff (rst)
      fall_stb |=> !fall_stb);

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
   import bclk_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             src_sel,
   input  logic             ext_clk,
   input  logic [DIV_W-1:0] divisor,
   input  logic             pol,
   output logic             bclk,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic      src_lvl;
   logic      src_tick;
   logic      raw_lvl;
   src_mode_e mode;

   assign mode = src_mode_e'(src_sel);

   bclk_src #(
      .PRESCALE    (PRESCALE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode),
      .ext_clk  (ext_clk),
      .src_lvl  (src_lvl),
      .src_tick (src_tick)
   );

   bclk_div_core #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .divisor  (divisor),
      .src_lvl  (src_lvl),
      .src_tick (src_tick),
      .raw_lvl  (raw_lvl)
   );

   bclk_edge_out u_out (
      .clk      (clk),
      .rst      (rst),
      .raw_lvl  (raw_lvl),
      .pol      (pol),
      .bclk     (bclk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   assert_reset_quiet_R8: assert property (@(posedge clk)
      $past(rst) |-> (!rise_stb && !fall_stb && bclk == pol));

endmodule

// File: tb/bclk_gen_test.sv
`timescale 1ns/1ps
module bclk_gen_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       src_sel = 1'b1;
   logic       ext_clk = 1'b0;
   logic [7:0] divisor = 8'd0;
   logic       pol = 1'b0;
   logic       bclk;
   logic       rise_stb;
   logic       fall_stb;

   int checks = 0;
   int errors = 0;
   int stb_err = 0;
   int rise_seen = 0;
   bit done = 1'b0;
   bit raw_prev = 1'b0;

   always #2 clk = ~clk;

   bclk_gen uut (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .src_sel  (src_sel),
      .ext_clk  (ext_clk),
      .divisor  (divisor),
      .pol      (pol),
      .bclk     (bclk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   // External clock: 5 system cycles high, 5 low.
   initial begin
      forever begin
         repeat (5) @(negedge clk);
         ext_clk = ~ext_clk;
      end
   end

   // R6 strobe monitor, sampled a quarter cycle after the falling edge.
   always @(negedge clk) begin
      #1;
      if (rst) begin
         raw_prev = 1'b0;
      end else begin
         if (rise_stb !== ((bclk ^ pol) & ~raw_prev) ||
             fall_stb !== (~(bclk ^ pol) & raw_prev))
            stb_err++;
         if ((bclk ^ pol) && !raw_prev) rise_seen++;
         raw_prev = bclk ^ pol;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic bit rawv();
      return bclk ^ pol;
   endfunction

   task automatic wait_level(input bit lvl, input string req);
      for (int i = 0; i < 20000; i++) begin
         step();
         if (rawv() == lvl) return;
      end
      chk(1'b0, req, "level never reached", 0, int'(lvl));
   endtask

   // Called on the sample where the output has just risen; returns on the next rise.
   task automatic hl(output int hi, output int lo);
      hi = 1;
      lo = 0;
      for (int i = 0; i < 20000; i++) begin
         step();
         if (rawv()) hi++;
         else break;
      end
      lo = 1;
      for (int i = 0; i < 20000; i++) begin
         step();
         if (!rawv()) lo++;
         else break;
      end
   endtask

   task automatic restart(input int n);
      en = 1'b0;
      divisor = 8'(n);
      repeat (3) step();
      chk(bclk == pol, "R9", "parked level", int'(bclk), int'(pol));
      en = 1'b1;
      step();
      if (n != 0)
         chk(rawv() == 1'b1, "R9", "high after enable", int'(rawv()), 1);
   endtask

   task automatic sweep_one(input int n, input int unit, input string req_src);
      int h1, l1, h2, l2, exp_h, exp_l;
      restart(n);
      wait_level(1'b0, "R2");
      wait_level(1'b1, "R2");
      hl(h1, l1);
      hl(h2, l2);
      if (n == 0) begin
         exp_h = unit / 2;
         exp_l = unit - unit / 2;
         chk(h2 == exp_h, "R4", "bypass high", h2, exp_h);
         chk(l2 == exp_l, "R4", "bypass low", l2, exp_l);
         chk(h1 + l1 == unit, req_src, "bypass period", h1 + l1, unit);
      end else begin
         exp_h = (n / 2 + 1) * unit;
         exp_l = (n - n / 2) * unit;
         chk(h2 == exp_h, "R3", $sformatf("high N=%0d", n), h2, exp_h);
         chk(l2 == exp_l, "R3", $sformatf("low N=%0d", n), l2, exp_l);
         chk(h1 + l1 == (n + 1) * unit, "R2", $sformatf("period N=%0d", n),
             h1 + l1, (n + 1) * unit);
         chk(h2 + l2 == (n + 1) * unit, req_src, $sformatf("src period N=%0d", n),
             h2 + l2, (n + 1) * unit);
      end
   endtask

   // Watchdog: an expired run counts as a failed check.
   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "R2", "watchdog expired", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int h, l;
      // R8: reset state
      repeat (3) step();
      chk(bclk == 1'b0, "R8", "bclk in reset", int'(bclk), 0);
      chk(!rise_stb && !fall_stb, "R8", "strobes in reset",
          int'(rise_stb) + int'(fall_stb), 0);
      rst = 1'b0;
      repeat (4) step();
      chk(bclk == 1'b0, "R8", "bclk idle after reset", int'(bclk), 0);

      // System-clock source sweep (R1, R2, R3, R4)
      src_sel = 1'b1;
      for (int n = 0; n <= 40; n++) sweep_one(n, 4, "R1");
      sweep_one(254, 4, "R1");
      sweep_one(255, 4, "R1");

      // External source (R1)
      src_sel = 1'b0;
      sweep_one(0, 10, "R1");
      sweep_one(1, 10, "R1");
      sweep_one(2, 10, "R1");
      sweep_one(3, 10, "R1");
      sweep_one(6, 10, "R1");

      // Polarity (R5)
      src_sel = 1'b1;
      en = 1'b0;
      pol = 1'b1;
      repeat (3) step();
      chk(bclk == 1'b1, "R5", "inverted parked level", int'(bclk), 1);
      for (int n = 1; n <= 6; n++) sweep_one(n, 4, "R5");
      sweep_one(0, 4, "R5");
      en = 1'b0;
      pol = 1'b0;
      repeat (3) step();
      chk(bclk == 1'b0, "R5", "plain parked level", int'(bclk), 0);

      // Reload only at period end (R7)
      restart(4);
      wait_level(1'b0, "R7");
      wait_level(1'b1, "R7");
      divisor = 8'd7;
      hl(h, l);
      chk(h == 12, "R7", "old high kept", h, 12);
      chk(l == 8, "R7", "old low kept", l, 8);
      hl(h, l);
      chk(h == 16, "R7", "new high", h, 16);
      chk(l == 16, "R7", "new low", l, 16);
      repeat (3) step();
      divisor = 8'd2;
      wait_level(1'b0, "R7");
      wait_level(1'b1, "R7");
      hl(h, l);
      chk(h + l == 12, "R7", "period after mid change", h + l, 12);
      chk(h == 8, "R7", "high after mid change", h, 8);

      // Disable mid-period (R9)
      step();
      en = 1'b0;
      step();
      step();
      chk(bclk == pol, "R9", "parked after disable", int'(bclk), int'(pol));
      repeat (20) step();
      chk(bclk == pol, "R9", "stays parked", int'(bclk), int'(pol));

      // Strobes (R6)
      chk(stb_err == 0, "R6", "strobe mismatches", stb_err, 0);
      chk(rise_seen > 100, "R6", "rises observed", rise_seen, 101);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule